// File: doc/BRIEF.md
# FSK Caller-ID Byte Deframer

This block sits behind a 1200-baud FSK demodulator that carries caller-ID data. The demodulator may follow either the Bell 202 or the V.23 tone plan. The block sees the demodulated line as a single asynchronous bit. It hunts for the falling edge of a start bit and confirms that edge at the middle of the bit. It then samples eight data bits at their centres, least significant first, and checks the stop bit. Idle mark bits and any redundant stop bits between characters produce no output.

Each data bit is presented on a cleaned serial output. A one-cycle bit clock pulse marks the moment the bit was sampled. When a character ends with a valid stop bit, the byte is loaded into a parallel register that can be read at any time. A one-cycle byte-ready strobe also fires, and its rising edge sets a sticky interrupt flag that only software clears. A byte that completes while the interrupt is still pending overwrites the register and raises a sticky overrun flag. A stop bit sampled as 0 discards the character and raises a sticky framing-error flag. After a framing error, the block waits for the line to return to mark before it hunts again.

The byte output is a valid-only stream with no ready input, and it applies no back-pressure. A consumer either captures `byte_reg` in the cycle `byte_ready` is high, or reads it before the next character completes. Bit timing comes from a tick divider of `TICK_DIV` system clocks, with `OVS` ticks per bit. For 1200 baud, set `TICK_DIV` = f_clk / (1200 × `OVS`).

Top module: `fsk_byte_deframer`

## Requirements
- R1: After reset, `bit_data`, `bit_clk`, `byte_reg`, `byte_ready`, `irq`, `ovr_flag` and `ferr_flag` are all 0.
- R2: Mark (1) bits on an idle line produce no `bit_clk` pulse. A low pulse shorter than half a bit produces no `bit_clk` pulse and no byte.
- R3: A character is a 0 start bit, then eight data bits sent least significant bit first, then a 1 stop bit. After it, `byte_reg` holds the eight data bits with the first received bit at position 0.
- R4: Each character gives exactly eight `bit_clk` pulses, each one system clock wide. At each pulse, `bit_data` equals the next data bit in order b0..b7, and `bit_data` holds that value until the next pulse.
- R5: `byte_ready` is a one-cycle pulse. `byte_reg` changes only in a cycle where `byte_ready` is 1, and it already shows the new byte in that cycle.
- R6: `irq` goes to 1 in the cycle after `byte_ready` rises. It stays at 1 until a cycle in which `clr_irq` is 1. If a set and a clear fall in the same cycle, the set wins.
- R7: If the stop bit is sampled as 0, `byte_ready` stays 0, `byte_reg` keeps its value and `ferr_flag` goes to 1. The block then ignores the line until it returns to 1. `ferr_flag` stays at 1 until `clr_ferr` is 1.
- R8: A byte that completes while `irq` is 1 overwrites `byte_reg` and sets `ovr_flag` in the next cycle. `ovr_flag` stays at 1 until `clr_ovr` is 1. A byte that completes while `irq` is 0 leaves `ovr_flag` at 0.
- R9: A start bit that follows a stop bit directly, with no idle mark in between, is received correctly.
- R10: Within one character, consecutive `bit_clk` pulses are exactly `OVS` × `TICK_DIV` system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Demodulated serial line (asynchronous), idle level 1 |
| clr_irq | input | 1 | Software clear strobe for the receive interrupt flag |
| clr_ovr | input | 1 | Software clear strobe for the overrun flag |
| clr_ferr | input | 1 | Software clear strobe for the framing-error flag |
| bit_data | output | 1 | Last sampled data bit (start, stop and mark bits removed) |
| bit_clk | output | 1 | One-cycle pulse per data bit, coincident with a new `bit_data` |
| byte_reg | output | NBITS | Last correctly framed byte, readable at any time |
| byte_ready | output | 1 | One-cycle valid strobe when `byte_reg` is loaded (no ready input) |
| irq | output | 1 | Sticky receive interrupt flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| ferr_flag | output | 1 | Sticky framing-error flag |

## Verification
The bench drives `ser_in` one bit every `OVS` × `TICK_DIV` clocks, with all inputs changed on falling edges. A monitor samples on every falling edge. This lets it count `bit_clk` pulses and measure the exact clock spacing between them, and it compares `byte_reg` with its own assembled bits in the same cycle `byte_ready` shows 1. Sampling takes place at mid-stop-bit, so `byte_ready`, and `irq`/`ovr_flag` one cycle later, are settled well before the bench finishes driving the stop bit. That is where the byte and flag checks sample. A clear strobe is held across exactly one rising edge, and the flag is read at the next falling edge. The set-wins case raises `clr_irq` in the very cycle `byte_ready` is seen.

// File: rtl/fsk_deframer_pkg.sv
package fsk_deframer_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_REARM
  } frame_st_t;
endpackage

// File: rtl/fsk_line_sync.sv
module fsk_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], line_async};
  end

  assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (cnt == W'(DIV - 1))  cnt <= '0;
        else                          cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == W'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/fsk_frame_fsm.sv
module fsk_frame_fsm
  import fsk_deframer_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  output logic samp_stb,
  output logic samp_val,
  output logic ok_stb,
  output logic bad_stb
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(NBITS + 1);
  localparam int HALF = OVS / 2;

  frame_st_t       state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      idx      <= '0;
      samp_stb <= 1'b0;
      samp_val <= 1'b0;
      ok_stb   <= 1'b0;
      bad_stb  <= 1'b0;
    end else begin
      samp_stb <= 1'b0;
      ok_stb   <= 1'b0;
      bad_stb  <= 1'b0;
      if (tick) begin
        case (state)
          ST_HUNT: begin
            if (!line) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              idx <= '0;
              state <= line ? ST_HUNT : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt      <= '0;
              samp_stb <= 1'b1;
              samp_val <= line;
              if (idx == IW'(NBITS - 1)) state <= ST_STOP;
              else                       idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              if (line) begin
                ok_stb <= 1'b1;
                state  <= ST_HUNT;
              end else begin
                bad_stb <= 1'b1;
                state   <= ST_REARM;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_REARM: begin
            if (line) state <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsk_byte_store.sv
module fsk_byte_store #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_stb,
  input  logic             samp_val,
  input  logic             ok_stb,
  output logic [NBITS-1:0] byte_reg,
  output logic             byte_ready
);
  logic [NBITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      byte_reg   <= '0;
      byte_ready <= 1'b0;
    end else begin
      byte_ready <= ok_stb;
      if (samp_stb) shreg <= {samp_val, shreg[NBITS-1:1]};
      if (ok_stb)   byte_reg <= shreg;
    end
  end
endmodule

// File: rtl/fsk_flags.sv
module fsk_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_ready,
  input  logic bad_stb,
  input  logic clr_irq,
  input  logic clr_ovr,
  input  logic clr_ferr,
  output logic irq,
  output logic ovr_flag,
  output logic ferr_flag
);
  logic rdy_q;
  logic rdy_rise;

  assign rdy_rise = byte_ready & ~rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      irq       <= 1'b0;
      ovr_flag  <= 1'b0;
      ferr_flag <= 1'b0;
    end else begin
      rdy_q     <= byte_ready;
      irq       <= rdy_rise | (irq & ~clr_irq);
      ovr_flag  <= (rdy_rise & irq) | (ovr_flag & ~clr_ovr);
      ferr_flag <= bad_stb | (ferr_flag & ~clr_ferr);
    end
  end
endmodule

// File: rtl/fsk_byte_deframer.sv
module fsk_byte_deframer #(
  parameter int TICK_DIV = 4,
  parameter int OVS      = 16,
  parameter int NBITS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             clr_irq,
  input  logic             clr_ovr,
  input  logic             clr_ferr,
  output logic             bit_data,
  output logic             bit_clk,
  output logic [NBITS-1:0] byte_reg,
  output logic             byte_ready,
  output logic             irq,
  output logic             ovr_flag,
  output logic             ferr_flag
);
  logic line_s;
  logic tick;
  logic samp_stb;
  logic samp_val;
  logic ok_stb;
  logic bad_stb;

  fsk_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_async(ser_in), .line_sync(line_s)
  );

  fsk_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  fsk_frame_fsm #(.OVS(OVS), .NBITS(NBITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .samp_stb(samp_stb), .samp_val(samp_val),
    .ok_stb(ok_stb), .bad_stb(bad_stb)
  );

  fsk_byte_store #(.NBITS(NBITS)) u_store (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .samp_val(samp_val),
    .ok_stb(ok_stb), .byte_reg(byte_reg), .byte_ready(byte_ready)
  );

  fsk_flags u_flags (
    .clk(clk), .rst_n(rst_n), .byte_ready(byte_ready), .bad_stb(bad_stb),
    .clr_irq(clr_irq), .clr_ovr(clr_ovr), .clr_ferr(clr_ferr),
    .irq(irq), .ovr_flag(ovr_flag), .ferr_flag(ferr_flag)
  );

  assign bit_clk  = samp_stb;
  assign bit_data = samp_val;
endmodule

// File: rtl/fsk_deframer_chk.sv
module fsk_deframer_chk #(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_irq,
  input logic             clr_ovr,
  input logic             clr_ferr,
  input logic             bit_clk,
  input logic [NBITS-1:0] byte_reg,
  input logic             byte_ready,
  input logic             irq,
  input logic             ovr_flag,
  input logic             ferr_flag
);
  // R4
  bit_clk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk |=> !bit_clk);
  // R4
  bit_vs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_clk && byte_ready));
  // R5
  ready_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |=> !byte_ready);
  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ready |-> $stable(byte_reg));
  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_ready) |=> irq);
  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_irq) |=> irq);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready && irq) |=> ovr_flag);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |=> ovr_flag);
  // R7
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_flag && !clr_ferr) |=> ferr_flag);
endmodule

bind fsk_byte_deframer fsk_deframer_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_irq(clr_irq), .clr_ovr(clr_ovr),
  .clr_ferr(clr_ferr), .bit_clk(bit_clk), .byte_reg(byte_reg),
  .byte_ready(byte_ready), .irq(irq), .ovr_flag(ovr_flag),
  .ferr_flag(ferr_flag)
);

// File: tb/sim_fsk_byte_deframer.sv
`timescale 1ns/1ps
module sim_fsk_byte_deframer;
  localparam int TICK_DIV = 4;
  localparam int OVS      = 16;
  localparam int BITCLKS  = TICK_DIV * OVS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b1;
  logic clr_irq = 1'b0, clr_ovr = 1'b0, clr_ferr = 1'b0;
  logic bit_data, bit_clk, byte_ready, irq, ovr_flag, ferr_flag;
  logic [7:0] byte_reg;

  int nchk = 0, nerr = 0;
  int cyc = 0, last_clk_cyc = 0, frame_bits = 0;
  int mon_nclk = 0, mon_nbytes = 0;
  logic [7:0] mon_bits = '0;

  always #5 clk = ~clk;

  fsk_byte_deframer #(.TICK_DIV(TICK_DIV), .OVS(OVS), .NBITS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .clr_irq(clr_irq),
    .clr_ovr(clr_ovr), .clr_ferr(clr_ferr), .bit_data(bit_data),
    .bit_clk(bit_clk), .byte_reg(byte_reg), .byte_ready(byte_ready),
    .irq(irq), .ovr_flag(ovr_flag), .ferr_flag(ferr_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] frame_of(input logic [7:0] b, input logic stopv);
    return {stopv, b, 1'b0};
  endfunction

  function automatic logic ovr_expect(input logic irq_before, input logic ovr_before);
    return irq_before | ovr_before;
  endfunction

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && bit_clk) begin
      if (frame_bits != 0)
        chk(cyc - last_clk_cyc == BITCLKS, "R10 bit spacing",
            32'(cyc - last_clk_cyc), 32'(BITCLKS));
      last_clk_cyc = cyc;
      frame_bits   = (frame_bits + 1) % 8;
      mon_bits     = {bit_data, mon_bits[7:1]};
      mon_nclk++;
    end
    if (rst_n && byte_ready) begin
      mon_nbytes++;
      chk(byte_reg == mon_bits, "R4 bit_data stream vs byte", 32'(byte_reg),
          32'(mon_bits));
    end
  end

  task automatic drive_bit(input logic v);
    ser_in = v;
    repeat (BITCLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stopv, input int marks);
    logic [9:0] f;
    f = frame_of(b, stopv);
    for (int m = 0; m < marks; m++) drive_bit(1'b1);
    for (int i = 0; i < 10; i++) drive_bit(f[i]);
  endtask

  task automatic pulse_clr(input int which);
    if (which == 0) clr_irq = 1'b1;
    else if (which == 1) clr_ovr = 1'b1;
    else clr_ferr = 1'b1;
    @(negedge clk);
    clr_irq = 1'b0; clr_ovr = 1'b0; clr_ferr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG timeout", 0, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int nb;
    logic [7:0] b;
    logic irq_b, ovr_b;
    int marks;
    void'($urandom(32'h00C1D5EE));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({bit_data, bit_clk, byte_reg, byte_ready, irq, ovr_flag, ferr_flag} == '0,
        "R1 reset outputs", 32'({byte_reg, irq, ovr_flag, ferr_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(byte_reg == 8'h00 && !irq, "R1 after release", 32'(byte_reg), 0);

    // R2 idle marks and a short glitch
    drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1);
    chk(mon_nclk == 0, "R2 idle marks", 32'(mon_nclk), 0);
    ser_in = 1'b0; repeat (BITCLKS / 2 - 12) @(negedge clk);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(mon_nclk == 0 && mon_nbytes == 0, "R2 glitch rejected", 32'(mon_nclk), 0);

    // R3 R4 R5 R6 directed frame
    send_frame(8'hA5, 1'b1, 2);
    chk(byte_reg == 8'hA5, "R3 byte value", 32'(byte_reg), 32'hA5);
    chk(mon_nclk == 8, "R4 eight bit clocks", 32'(mon_nclk), 8);
    chk(mon_nbytes == 1, "R5 one byte_ready", 32'(mon_nbytes), 1);
    chk(irq == 1'b1, "R6 irq set", 32'(irq), 1);
    chk(bit_data == 1'b1, "R4 bit_data holds b7", 32'(bit_data), 1);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(irq == 1'b1, "R6 irq sticky", 32'(irq), 1);
    pulse_clr(0);
    chk(irq == 1'b0, "R6 irq cleared", 32'(irq), 0);

    // R8 overrun
    send_frame(8'h3C, 1'b1, 1);
    chk(ovr_flag == 1'b0, "R8 no overrun when irq clear", 32'(ovr_flag), 0);
    send_frame(8'h81, 1'b1, 3);
    chk(byte_reg == 8'h81, "R8 byte overwritten", 32'(byte_reg), 32'h81);
    chk(ovr_flag == 1'b1, "R8 overrun set", 32'(ovr_flag), 1);
    pulse_clr(1);
    chk(ovr_flag == 1'b0, "R8 overrun cleared", 32'(ovr_flag), 0);
    pulse_clr(0);

    // R7 framing error
    nb = mon_nbytes;
    send_frame(8'h55, 1'b0, 1);
    drive_bit(1'b1); drive_bit(1'b1);
    chk(ferr_flag == 1'b1, "R7 ferr set", 32'(ferr_flag), 1);
    chk(byte_reg == 8'h81, "R7 byte kept", 32'(byte_reg), 32'h81);
    chk(mon_nbytes == nb, "R7 no byte_ready", 32'(mon_nbytes), 32'(nb));
    chk(irq == 1'b0, "R7 no irq", 32'(irq), 0);
    pulse_clr(2);
    chk(ferr_flag == 1'b0, "R7 ferr cleared", 32'(ferr_flag), 0);
    send_frame(8'h6E, 1'b1, 0);
    chk(byte_reg == 8'h6E, "R7 recovery frame", 32'(byte_reg), 32'h6E);
    pulse_clr(0);

    // R6 set wins over clear in the same cycle
    fork
      send_frame(8'h42, 1'b1, 1);
      begin
        @(negedge clk iff byte_ready);
        clr_irq = 1'b1;
        @(negedge clk);
        clr_irq = 1'b0;
      end
    join
    chk(irq == 1'b1, "R6 set wins", 32'(irq), 1);
    pulse_clr(0);

    // R3 R8 R9 random frames, some back-to-back
    for (int k = 0; k < 24; k++) begin
      b = 8'($urandom);
      marks = int'($urandom % 4);
      if ($urandom % 2 == 1) pulse_clr(0);
      irq_b = irq; ovr_b = ovr_flag;
      nb = mon_nbytes;
      send_frame(b, 1'b1, marks);
      chk(byte_reg == b, marks == 0 ? "R9 back-to-back byte" : "R3 random byte",
          32'(byte_reg), 32'(b));
      chk(mon_nbytes == nb + 1, "R5 one strobe per frame", 32'(mon_nbytes),
          32'(nb + 1));
      chk(ovr_flag == ovr_expect(irq_b, ovr_b), "R8 random overrun",
          32'(ovr_flag), 32'(ovr_expect(irq_b, ovr_b)));
      chk(irq == 1'b1, "R6 random irq", 32'(irq), 1);
    end
    drive_bit(1'b1);
    chk(mon_nclk == 8 * mon_nbytes + 8, "R4 total bit clocks", 32'(mon_nclk),
        32'(8 * mon_nbytes + 8));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule